// File: doc/BRIEF.md
# Timer Register Burst Window

This block sits next to a timer's register file and lets a DMA engine fetch or load a contiguous run of timer registers through one fixed address. A control register holds a starting register index and a run length. While a burst is in progress, each bus access to the window address is steered to the register at the starting index plus a running step. The step advances after every window access and falls back to zero once the run is complete.

Seven timer events feed the block: capture channels 1 to 4, update, trigger and commutation. Each event always sets its own status flag. When the matching request-enable bit is also set, the event raises `dma_req`. The request stays high until the last window access of the run. The block owns the enable, status, control and window registers. Every other implemented offset is passed straight through to the timer register file port.

Top module: `tmr_dma_window`

## Requirements
- R1: After reset `dma_req` is low, and the enable register (byte offset 0x0C), status register (0x10) and control register (0x48) all read zero.
- R2: In the control register, bits 4:0 hold the starting register index and bits 12:8 hold the run length minus one. All other bits read zero.
- R3: An access to byte offset 0x4C is redirected to the register whose byte offset is 4 × (start index + step). Reads return that register's value and writes land in it.
- R4: The step advances by one after each window access. After length-minus-one + 1 accesses it returns to zero, so the next access targets the start index again.
- R5: An event whose enable bit is set raises `dma_req` at the clock edge that samples it. The request stays high until the window access that uses the last step and is low after that access.
- R6: Request-enable bits sit at update 8, capture 1 to 4 at bits 9 to 12, commutation 13 and trigger 14. The event inputs `evt_i[6:0]` are ordered ch1, ch2, ch3, ch4, update, trigger, commutation. An event whose enable bit is clear raises no request.
- R7: Status flags sit at update 0, capture 1 to 4 at bits 1 to 4, commutation 5 and trigger 6. Every event sets its flag. A status write clears each flag written as 0 and keeps each flag written as 1.
- R8: Writing an enable bit to 1 while its flag is already pending starts a request. If the flag was cleared first, enabling starts nothing.
- R9: Events that arrive while a burst is active are not queued. Once the burst ends `dma_req` stays low, and only the flags record those events.
- R10: Any write to the control register ends an active burst (`dma_req` low after that write) and resets the step to zero.
- R11: Clearing the enable bit of the source that started the active burst ends the burst at that write.
- R12: A window target of index 20 or above, or the window register itself, reads zero and passes no write to the register file. Direct reads of unimplemented offsets up to 0x3FC also read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| evt_i | input | 7 | Event pulses: ch1, ch2, ch3, ch4, update, trigger, commutation |
| dma_req | output | 1 | Burst request to the DMA engine |
| rf_sel | output | 1 | Access forwarded to the timer register file |
| rf_we | output | 1 | Forwarded access is a write |
| rf_idx | output | 8 | Word index of the forwarded access |
| rf_wdata | output | 32 | Forwarded write data |
| rf_rdata | input | 32 | Register file read data |

## Verification
The hardest situations to reach are the ones where a second stimulus lands inside a burst that is still running. Examples are a new event mid-run, a control rewrite, or the enable of the running source being cleared. The bench starts a burst with a length greater than one and consumes only part of it through window reads. It then applies the disturbing access and checks `dma_req` together with the target of the next window read. The stale-flag case is reached by letting an event set its flag while its enable bit is clear, then writing the enable register, with and without a status clear in between.

// File: rtl/tdw_pkg.sv
`timescale 1ns/1ps
package tdw_pkg;
    localparam int N_SRC   = 7;
    localparam int FLAG_W  = 7;
    localparam int EN_LSB  = 8;
    localparam int FLD_W   = 5;
    localparam int LEN_LSB = 8;
    localparam int IDX_EN  = 3;
    localparam int IDX_ST  = 4;
    localparam int IDX_CTL = 18;
    localparam int IDX_WIN = 19;

    // event input order -> status / enable bit position (minus EN_LSB)
    function automatic int src_flag_pos(input int s);
        case (s)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 0;
            5: return 6;
            default: return 5;
        endcase
    endfunction

    typedef enum logic [2:0] {SEL_NONE, SEL_EN, SEL_ST, SEL_CTL, SEL_RF} sel_e;

    typedef struct packed {
        logic [FLAG_W-1:0] en;
        logic [FLAG_W-1:0] flag;
    } evt_state_t;

    typedef struct packed {
        logic [FLD_W-1:0]  base;
        logic [FLD_W-1:0]  len;
        logic [FLD_W-1:0]  step;
        logic              busy;
        logic [FLAG_W-1:0] act;
    } seq_state_t;
endpackage

// File: rtl/tdw_decode.sv
`timescale 1ns/1ps
module tdw_decode
    import tdw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int IMPL_REGS = 20,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FLD_W-1:0]  base,
    input  logic [FLD_W-1:0]  step,
    output logic              win_acc,
    output logic [IDX_W-1:0]  eff_idx,
    output sel_e              sel
);
    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] win_idx;

    always_comb begin
        dir_idx = bus_addr[ADDR_W-1:2];
        win_idx = IDX_W'(base) + IDX_W'(step);
        win_acc = bus_valid && (dir_idx == IDX_W'(IDX_WIN));
        eff_idx = win_acc ? win_idx : dir_idx;
        sel     = SEL_NONE;
        if (bus_valid) begin
            if (eff_idx == IDX_W'(IDX_EN))       sel = SEL_EN;
            else if (eff_idx == IDX_W'(IDX_ST))  sel = SEL_ST;
            else if (eff_idx == IDX_W'(IDX_CTL)) sel = SEL_CTL;
            else if (eff_idx == IDX_W'(IDX_WIN)) sel = SEL_NONE;
            else if (eff_idx < IDX_W'(IMPL_REGS)) sel = SEL_RF;
        end
    end
endmodule

// File: rtl/tdw_evt.sv
`timescale 1ns/1ps
module tdw_evt
    import tdw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic              en_we,
    input  logic              st_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [FLAG_W-1:0] en_q,
    output logic [FLAG_W-1:0] en_next,
    output logic [FLAG_W-1:0] flag_q,
    output logic              start,
    output logic [FLAG_W-1:0] start_oh
);
    evt_state_t        st_d, st_q;
    logic [FLAG_W-1:0] evt_fl;
    logic [FLAG_W-1:0] trig;
    logic [FLAG_W-1:0] new_en;

    always_comb begin
        evt_fl = '0;
        for (int s = 0; s < N_SRC; s++) begin
            evt_fl[src_flag_pos(s)] = evt_i[s];
        end
        new_en = wdata[EN_LSB +: FLAG_W];
        st_d = st_q;
        if (en_we) st_d.en = new_en;
        if (st_we) st_d.flag = st_q.flag & wdata[FLAG_W-1:0];
        st_d.flag = st_d.flag | evt_fl;
        // fresh enabled events, or a pending flag whose enable is being set
        trig = (evt_fl & st_q.en) |
               (en_we ? (new_en & ~st_q.en & st_q.flag) : '0);
        start_oh = '0;
        for (int s = N_SRC - 1; s >= 0; s--) begin
            if (trig[src_flag_pos(s)]) begin
                start_oh = '0;
                start_oh[src_flag_pos(s)] = 1'b1;
            end
        end
        start = (|trig) && !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q    = st_q.en;
    assign en_next = st_d.en;
    assign flag_q  = st_q.flag;

    a_r7_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_fl) |=> ((flag_q & $past(evt_fl)) == $past(evt_fl)));
endmodule

// File: rtl/tdw_seq.sv
`timescale 1ns/1ps
module tdw_seq
    import tdw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              win_acc,
    input  logic              start,
    input  logic [FLAG_W-1:0] start_oh,
    input  logic [FLAG_W-1:0] en_next,
    output logic [FLD_W-1:0]  base,
    output logic [FLD_W-1:0]  len,
    output logic [FLD_W-1:0]  step,
    output logic              busy
);
    seq_state_t sq_d, sq_q;
    logic       last_acc;
    logic       src_live;

    always_comb begin
        sq_d     = sq_q;
        last_acc = win_acc && (sq_q.step == sq_q.len);
        src_live = |(sq_q.act & en_next);
        if (win_acc) sq_d.step = last_acc ? '0 : sq_q.step + 1'b1;
        if (last_acc) sq_d.busy = 1'b0;
        if (sq_q.busy && !src_live) sq_d.busy = 1'b0;
        if (!sq_q.busy && start) begin
            sq_d.busy = 1'b1;
            sq_d.act  = start_oh;
        end
        if (ctl_we) begin
            sq_d.base = wdata[FLD_W-1:0];
            sq_d.len  = wdata[LEN_LSB +: FLD_W];
            sq_d.step = '0;
            sq_d.busy = 1'b0;
        end
        if (!sq_d.busy) sq_d.act = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign base = sq_q.base;
    assign len  = sq_q.len;
    assign step = sq_q.step;
    assign busy = sq_q.busy;

    a_r4_step_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.step <= sq_q.len);
    a_r5_drop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.busy && win_acc && sq_q.step == sq_q.len) |=> !sq_q.busy);
    a_r5_hold_mid_run: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.busy && !ctl_we && !win_acc && src_live) |=> sq_q.busy);
    a_r10_ctl_resets: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (sq_q.step == '0 && !sq_q.busy));
    a_r11_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.busy |-> $onehot(sq_q.act));
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.busy && !src_live) |=> !sq_q.busy);
endmodule

// File: rtl/tmr_dma_window.sv
`timescale 1ns/1ps
module tmr_dma_window
    import tdw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int IMPL_REGS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [6:0]        evt_i,
    output logic              dma_req,
    output logic              rf_sel,
    output logic              rf_we,
    output logic [ADDR_W-3:0] rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    localparam int IDX_W = ADDR_W - 2;

    sel_e              sel;
    logic              win_acc;
    logic [IDX_W-1:0]  eff_idx;
    logic [FLD_W-1:0]  base, len, step;
    logic              busy;
    logic [FLAG_W-1:0] en_q, en_next, flag_q, start_oh;
    logic              start;
    logic              en_we, st_we, ctl_we;

    tdw_decode #(.ADDR_W(ADDR_W), .IMPL_REGS(IMPL_REGS)) u_decode (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .base      (base),
        .step      (step),
        .win_acc   (win_acc),
        .eff_idx   (eff_idx),
        .sel       (sel)
    );

    assign en_we  = bus_write && (sel == SEL_EN);
    assign st_we  = bus_write && (sel == SEL_ST);
    assign ctl_we = bus_write && (sel == SEL_CTL);

    tdw_evt #(.DATA_W(DATA_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .en_we    (en_we),
        .st_we    (st_we),
        .wdata    (bus_wdata),
        .busy     (busy),
        .en_q     (en_q),
        .en_next  (en_next),
        .flag_q   (flag_q),
        .start    (start),
        .start_oh (start_oh)
    );

    tdw_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .wdata    (bus_wdata),
        .win_acc  (win_acc),
        .start    (start),
        .start_oh (start_oh),
        .en_next  (en_next),
        .base     (base),
        .len      (len),
        .step     (step),
        .busy     (busy)
    );

    always_comb begin
        rf_sel    = (sel == SEL_RF);
        rf_we     = rf_sel && bus_write;
        rf_idx    = eff_idx;
        rf_wdata  = bus_wdata;
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (sel)
                SEL_EN:  bus_rdata[EN_LSB +: FLAG_W] = en_q;
                SEL_ST:  bus_rdata[FLAG_W-1:0] = flag_q;
                SEL_CTL: begin
                    bus_rdata[FLD_W-1:0]       = base;
                    bus_rdata[LEN_LSB +: FLD_W] = len;
                end
                SEL_RF:  bus_rdata = rf_rdata;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign dma_req = busy;

    a_r12_rf_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rf_sel |-> (rf_idx < IDX_W'(IMPL_REGS)));
    a_r3_window_steers: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_sel && bus_addr[ADDR_W-1:2] == IDX_W'(IDX_WIN)) |->
        (rf_idx == IDX_W'(base) + IDX_W'(step)));
endmodule

// File: tb/tmr_dma_window_tb.sv
`timescale 1ns/1ps
module tmr_dma_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt = '0;
    logic        dma_req;
    logic        rf_sel, rf_we;
    logic [7:0]  rf_idx;
    logic [31:0] rf_wdata, rf_rdata;

    logic [31:0] mem [0:63];
    int          rf_wr_cnt;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    // enable bit per source ch1,ch2,ch3,ch4,up,trig,com
    int en_bit [7] = '{9, 10, 11, 12, 8, 14, 13};

    always #10 clk = ~clk;

    tmr_dma_window u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt), .dma_req(dma_req), .rf_sel(rf_sel), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = mem[rf_idx[5:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA000_0000 + i;
            rf_wr_cnt <= 0;
        end else if (rf_sel && rf_we) begin
            mem[rf_idx[5:0]] <= rf_wdata;
            rf_wr_cnt <= rf_wr_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        evt[s] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 req after reset", {31'd0, dma_req}, 32'd0);
        bus_rd(10'h0C, d); chk("R1 enable reset", d, 32'd0);
        bus_rd(10'h10, d); chk("R1 status reset", d, 32'd0);
        bus_rd(10'h48, d); chk("R1 control reset", d, 32'd0);
    endtask

    task automatic t_ctl_fields();
        logic [31:0] d;
        bus_wr(10'h48, 32'hFFFF_FFFF);
        bus_rd(10'h48, d); chk("R2 control all ones", d, 32'h0000_1F1F);
        bus_wr(10'h48, 32'h0000_0A15);
        bus_rd(10'h48, d); chk("R2 control pattern", d, 32'h0000_0A15);
    endtask

    task automatic t_window_read();
        logic [31:0] d;
        bus_wr(10'h10, 0);
        bus_wr(10'h48, (2 << 8) | 5);
        bus_wr(10'h0C, 32'h200);
        pulse(0);
        chk("R5 req on enabled event", {31'd0, dma_req}, 1);
        bus_rd(10'h4C, d); chk("R3 window step0", d, 32'hA000_0005);
        chk("R5 req held", {31'd0, dma_req}, 1);
        bus_rd(10'h4C, d); chk("R4 window step1", d, 32'hA000_0006);
        chk("R5 req held 2", {31'd0, dma_req}, 1);
        bus_rd(10'h4C, d); chk("R4 window step2", d, 32'hA000_0007);
        chk("R5 req drop after last", {31'd0, dma_req}, 0);
        bus_rd(10'h4C, d); chk("R4 wrap to base", d, 32'hA000_0005);
    endtask

    task automatic t_window_write();
        logic [31:0] d;
        bus_wr(10'h48, 7);
        bus_wr(10'h4C, 32'h1234_5678);
        bus_rd(10'h1C, d); chk("R3 window write lands", d, 32'h1234_5678);
    endtask

    task automatic t_src_map();
        logic [31:0] d;
        for (int s = 0; s < 7; s++) begin
            bus_wr(10'h48, 0);
            bus_wr(10'h10, 0);
            bus_wr(10'h0C, 32'd1 << en_bit[s]);
            pulse(s);
            chk($sformatf("R6 src%0d req", s), {31'd0, dma_req}, 1);
            bus_rd(10'h10, d);
            chk($sformatf("R7 src%0d flag", s), d, 32'd1 << (en_bit[s] - 8));
            bus_rd(10'h4C, d);
            chk($sformatf("R5 src%0d single", s), {31'd0, dma_req}, 0);
            bus_wr(10'h10, 0);
            bus_wr(10'h0C, 32'h7F00 & ~(32'd1 << en_bit[s]));
            pulse(s);
            chk($sformatf("R6 src%0d masked", s), {31'd0, dma_req}, 0);
            bus_rd(10'h10, d);
            chk($sformatf("R7 src%0d masked flag", s), d, 32'd1 << (en_bit[s] - 8));
        end
    endtask

    task automatic t_status_clear();
        logic [31:0] d;
        bus_wr(10'h0C, 0);
        bus_wr(10'h10, 0);
        pulse(4); pulse(5);
        bus_rd(10'h10, d); chk("R7 two flags", d, 32'h41);
        bus_wr(10'h10, 32'h01);
        bus_rd(10'h10, d); chk("R7 keep written one", d, 32'h01);
        bus_wr(10'h10, 0);
        bus_rd(10'h10, d); chk("R7 clear by zero", d, 32'h00);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        bus_wr(10'h48, 0);
        pulse(5);
        chk("R8 no req while disabled", {31'd0, dma_req}, 0);
        bus_wr(10'h0C, 32'h4000);
        chk("R8 pending flag starts", {31'd0, dma_req}, 1);
        bus_rd(10'h4C, d);
        bus_wr(10'h0C, 0);
        bus_wr(10'h10, 0);
        pulse(5);
        bus_wr(10'h10, 0);
        bus_wr(10'h0C, 32'h4000);
        chk("R8 cleared flag no start", {31'd0, dma_req}, 0);
    endtask

    task automatic t_no_queue();
        logic [31:0] d;
        bus_wr(10'h48, 32'h100);
        bus_wr(10'h10, 0);
        bus_wr(10'h0C, 32'h0C00);
        pulse(1);
        chk("R9 first burst", {31'd0, dma_req}, 1);
        pulse(2);
        bus_rd(10'h4C, d);
        bus_rd(10'h4C, d);
        chk("R9 burst ends", {31'd0, dma_req}, 0);
        repeat (3) @(negedge clk);
        chk("R9 no queued burst", {31'd0, dma_req}, 0);
        bus_rd(10'h10, d); chk("R9 flags record", d, 32'h0C);
    endtask

    task automatic t_ctl_abort();
        logic [31:0] d;
        bus_wr(10'h48, (3 << 8) | 5);
        bus_wr(10'h10, 0);
        bus_wr(10'h0C, 32'h200);
        pulse(0);
        bus_rd(10'h4C, d);
        chk("R10 mid burst", {31'd0, dma_req}, 1);
        bus_wr(10'h48, (3 << 8) | 8);
        chk("R10 ctl write aborts", {31'd0, dma_req}, 0);
        bus_rd(10'h4C, d); chk("R10 step reset", d, 32'hA000_0008);
    endtask

    task automatic t_en_abort();
        bus_wr(10'h48, 3 << 8);
        pulse(0);
        chk("R11 burst running", {31'd0, dma_req}, 1);
        bus_wr(10'h0C, 0);
        chk("R11 enable clear aborts", {31'd0, dma_req}, 0);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        int c0;
        c0 = rf_wr_cnt;
        bus_wr(10'h48, 20);
        bus_rd(10'h4C, d); chk("R12 window beyond reads zero", d, 0);
        bus_wr(10'h4C, 32'hDEAD);
        chk("R12 no rf write beyond", rf_wr_cnt, c0);
        bus_rd(10'h50, d); chk("R12 direct unimpl", d, 0);
        bus_rd(10'h3FC, d); chk("R12 top offset", d, 0);
        bus_wr(10'h48, 19);
        bus_rd(10'h4C, d); chk("R12 window on itself", d, 0);
        bus_wr(10'h4C, 32'hBEEF);
        chk("R12 no rf write self", rf_wr_cnt, c0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_ctl_fields();
        t_window_read();
        t_window_write();
        t_src_map();
        t_status_clear();
        t_pending();
        t_no_queue();
        t_ctl_abort();
        t_en_abort();
        t_unimpl();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule